// File: doc/BRIEF.md
# Synchronous Serial Byte Receiver

This block receives 8-bit frames over a clocked serial link and hands them to a host one byte at a time. As clock master it generates the serial clock itself from the system clock through a fixed even divider. As clock slave it takes the serial clock from outside, passes it and the data line through a synchroniser, and samples on each detected rising edge. In both cases data is sampled on the rising serial clock edge, most significant bit first.

The host sees a byte register with a read strobe, a small control field and a status field. In master mode the host paces the link with reads: the first read is a dummy read that launches the first frame, and every later read both collects a byte and launches the next frame. A stop request lets exactly one last frame run, after which reception switches itself off. If a frame completes while the previous byte is still unread, the block flags an overrun, keeps the old byte and stops receiving until the host clears the flag.

Top module: `ssrx_ctrl`

## Requirements
- R1: In master mode sck_o idles high. Each frame is 8 periods of CLK_DIV system clocks, low half first. sd_i is sampled on every rising edge of sck_o, MSB first.
- R2: In master mode a frame starts only on an rd_strobe seen while the enable bit (ctl bit 0) is 1, no frame is running and the overrun flag is 0. Without such a read, sck_o stays high.
- R3: After the eighth sampled bit the byte appears on rd_data and rx_full goes to 1. In master mode this happens CLK_DIV/2 + 7*CLK_DIV + 1 cycles after the clock edge that takes the starting read.
- R4: irq_rx equals rx_full AND ctl bit 2. irq_err equals overrun AND ctl bit 3.
- R5: An rd_strobe clears rx_full on the next clock edge.
- R6: In slave mode, with the enable bit set, sd_i is sampled on each rising edge of sck_i, after both have passed a SYNC_STAGES-deep synchroniser. Eight edges form one byte.
- R7: When a frame completes while the stop bit (ctl bit 1) is 1, the enable and stop bits both clear and the byte stays on rd_data. Later reads produce no clock edges on sck_o.
- R8: When a frame completes while rx_full is 1, overrun goes to 1. rd_data keeps the older byte and the new byte is lost.
- R9: While overrun is 1, serial edges are ignored and no master frame starts. An sts_we with sts_wdata 0 clears overrun, and reception then resumes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_master | input | 1 | 1 selects clock master, 0 selects clock slave |
| ctl_we | input | 1 | Write strobe for the control field |
| ctl_wdata | input | 4 | Control write data: bit0 enable, bit1 stop, bit2 receive irq enable, bit3 error irq enable |
| sts_we | input | 1 | Write strobe for the overrun status bit |
| sts_wdata | input | 1 | Value written to overrun (only 0 has an effect) |
| rd_strobe | input | 1 | Host read of the byte register |
| rd_data | output | DATA_W | Received byte register |
| ctl_rdata | output | 4 | Current control field |
| rx_full | output | 1 | Unread byte present |
| overrun | output | 1 | Overrun flag |
| irq_rx | output | 1 | Receive interrupt request |
| irq_err | output | 1 | Overrun error interrupt request |
| sck_o | output | 1 | Serial clock driven in master mode |
| sck_i | input | 1 | Serial clock from outside in slave mode |
| sd_i | input | 1 | Serial data input |

## Verification
In master mode a byte lands exactly CLK_DIV/2 + 7*CLK_DIV + 1 cycles after the edge that takes the starting read. The bench counts falling clock edges from that read and requires rx_full to rise on that exact count, not merely eventually. Slave timing depends on the synchroniser depth, so slave bytes are checked by a monitor at the cycle rx_full rises, against a queue the driver fills before each frame. Flag and interrupt effects of writes and reads are due one edge later. They are sampled on the falling edge that follows.

// File: rtl/ssrx_pkg.sv
package ssrx_pkg;
   localparam int CTL_W = 4;

   typedef struct packed {
      logic err_ie;
      logic rx_ie;
      logic stop;
      logic en;
   } ssrx_ctl_t;
endpackage

// File: rtl/ssrx_mclk.sv
module ssrx_mclk #(
   parameter int CLK_DIV = 4,
   parameter int BITS    = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic busy,
   output logic sck,
   output logic rise
);
   localparam int HALF = CLK_DIV / 2;
   localparam int CW   = (HALF > 1) ? $clog2(HALF) : 1;
   localparam int BW   = $clog2(BITS);

   initial assert (CLK_DIV >= 2 && (CLK_DIV % 2) == 0)
      else $fatal(1, "CLK_DIV must be even and at least 2");

   logic          busy_q, sck_q, tick;
   logic [BW-1:0] nbit_q;

   generate
      if (HALF == 1) begin : g_nodiv
         assign tick = busy_q;
      end else begin : g_div
         logic [CW-1:0] cnt_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                        cnt_q <= '0;
            else if (!busy_q)                  cnt_q <= '0;
            else if (cnt_q == CW'(HALF - 1))   cnt_q <= '0;
            else                               cnt_q <= cnt_q + 1'b1;
         end
         assign tick = busy_q && (cnt_q == CW'(HALF - 1));
      end
   endgenerate

   assign rise = tick && !sck_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         sck_q  <= 1'b1;
         nbit_q <= '0;
      end else if (start && !busy_q) begin
         busy_q <= 1'b1;
         sck_q  <= 1'b0;
         nbit_q <= '0;
      end else if (tick) begin
         if (!sck_q) begin
            sck_q <= 1'b1;
            if (nbit_q == BW'(BITS - 1)) busy_q <= 1'b0;
            else                         nbit_q <= nbit_q + 1'b1;
         end else begin
            sck_q <= 1'b0;
         end
      end
   end

   assign busy = busy_q;
   assign sck  = sck_q;

   AST_SCK_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_q |-> sck_q); // R1
endmodule

// File: rtl/ssrx_slv_front.sv
module ssrx_slv_front #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sck_in,
   input  logic sd_in,
   output logic sd_sync,
   output logic sck_rise
);
   initial assert (STAGES >= 2)
      else $fatal(1, "STAGES must be at least 2");

   logic [1:0] stg [STAGES];
   logic       sck_prev;

   generate
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      stg[i] <= 2'b01;
            else if (i == 0) stg[i] <= {sd_in, sck_in};
            else             stg[i] <= stg[(i > 0) ? i - 1 : 0];
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sck_prev <= 1'b1;
      else        sck_prev <= stg[STAGES-1][0];
   end

   assign sck_rise = stg[STAGES-1][0] && !sck_prev;
   assign sd_sync  = stg[STAGES-1][1];
endmodule

// File: rtl/ssrx_shift.sv
module ssrx_shift #(
   parameter int BITS = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            clr,
   input  logic            sample,
   input  logic            bit_in,
   output logic            done,
   output logic [BITS-1:0] data
);
   localparam int BW = $clog2(BITS);

   initial assert (BITS >= 2)
      else $fatal(1, "BITS must be at least 2");

   logic [BITS-1:0] sh_q;
   logic [BW-1:0]   cnt_q;
   logic            done_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_q   <= '0;
         cnt_q  <= '0;
         done_q <= 1'b0;
      end else if (clr) begin
         cnt_q  <= '0;
         done_q <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (sample) begin
            sh_q <= {sh_q[BITS-2:0], bit_in};
            if (cnt_q == BW'(BITS - 1)) begin
               cnt_q  <= '0;
               done_q <= 1'b1;
            end else begin
               cnt_q <= cnt_q + 1'b1;
            end
         end
      end
   end

   assign done = done_q;
   assign data = sh_q;

   AST_DONE_AFTER_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |-> $past(sample)); // R3
endmodule

// File: rtl/ssrx_ctrl.sv
module ssrx_ctrl
   import ssrx_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int CLK_DIV     = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_master,
   input  logic              ctl_we,
   input  logic [CTL_W-1:0]  ctl_wdata,
   input  logic              sts_we,
   input  logic              sts_wdata,
   input  logic              rd_strobe,
   output logic [DATA_W-1:0] rd_data,
   output logic [CTL_W-1:0]  ctl_rdata,
   output logic              rx_full,
   output logic              overrun,
   output logic              irq_rx,
   output logic              irq_err,
   output logic              sck_o,
   input  logic              sck_i,
   input  logic              sd_i
);
   ssrx_ctl_t         ctl_q;
   logic [DATA_W-1:0] rdr_q;
   logic              full_q, ovr_q;

   logic m_start, m_busy, m_sck, m_rise;
   logic s_sd, s_rise, s_enable;
   logic sample, bit_in, sh_clr;
   logic fr_done;
   logic [DATA_W-1:0] fr_data;

   assign m_start  = cfg_master && rd_strobe && ctl_q.en && !ovr_q && !m_busy;
   assign s_enable = !cfg_master && ctl_q.en && !ovr_q;
   assign sample   = cfg_master ? m_rise : (s_enable && s_rise);
   assign bit_in   = cfg_master ? sd_i : s_sd;
   assign sh_clr   = !ctl_q.en || ovr_q || m_start;

   ssrx_mclk #(.CLK_DIV(CLK_DIV), .BITS(DATA_W)) mclk_i (
      .clk(clk), .rst_n(rst_n), .start(m_start),
      .busy(m_busy), .sck(m_sck), .rise(m_rise)
   );

   ssrx_slv_front #(.STAGES(SYNC_STAGES)) front_i (
      .clk(clk), .rst_n(rst_n), .sck_in(sck_i), .sd_in(sd_i),
      .sd_sync(s_sd), .sck_rise(s_rise)
   );

   ssrx_shift #(.BITS(DATA_W)) shift_i (
      .clk(clk), .rst_n(rst_n), .clr(sh_clr), .sample(sample),
      .bit_in(bit_in), .done(fr_done), .data(fr_data)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl_q  <= '0;
         rdr_q  <= '0;
         full_q <= 1'b0;
         ovr_q  <= 1'b0;
      end else begin
         if (ctl_we) ctl_q <= ssrx_ctl_t'(ctl_wdata);
         if (fr_done && ctl_q.stop) begin
            ctl_q.en   <= 1'b0;
            ctl_q.stop <= 1'b0;
         end
         if (sts_we && !sts_wdata) ovr_q <= 1'b0;
         if (rd_strobe) full_q <= 1'b0;
         if (fr_done) begin
            if (full_q && !rd_strobe) begin
               ovr_q <= 1'b1;
            end else begin
               rdr_q  <= fr_data;
               full_q <= 1'b1;
            end
         end
      end
   end

   assign rd_data   = rdr_q;
   assign ctl_rdata = ctl_q;
   assign rx_full   = full_q;
   assign overrun   = ovr_q;
   assign irq_rx    = full_q && ctl_q.rx_ie;
   assign irq_err   = ovr_q && ctl_q.err_ie;
   assign sck_o     = m_sck;

   AST_FULL_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      fr_done && !full_q |=> full_q && (rdr_q == $past(fr_data))); // R3
   AST_RD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      rd_strobe && !fr_done |=> !full_q); // R5
   AST_OVR_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
      fr_done && full_q && !rd_strobe |=> ovr_q && $stable(rdr_q)); // R8
   AST_STOP_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
      fr_done && ctl_q.stop && !ctl_we |=> !ctl_q.en && !ctl_q.stop); // R7
   AST_OVR_NO_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
      ovr_q && !m_busy |=> !m_busy); // R9
endmodule

// File: tb/ssrx_ctrl_tb_top.sv
module ssrx_ctrl_tb_top;
   localparam int DW  = 8;
   localparam int DIV = 4;
   localparam int LAT = DIV / 2 + 7 * DIV + 1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cfg_master = 1'b1;
   logic ctl_we = 1'b0;
   logic [3:0] ctl_wdata = '0;
   logic sts_we = 1'b0;
   logic sts_wdata = 1'b0;
   logic rd_strobe = 1'b0;
   logic [DW-1:0] rd_data;
   logic [3:0] ctl_rdata;
   logic rx_full, overrun, irq_rx, irq_err, sck_o;
   logic s_sck = 1'b1;
   logic s_sd = 1'b0;
   logic m_sd = 1'b0;
   logic sd_i;

   int checks = 0;
   int errors = 0;
   int sck_falls = 0;
   int m_idx = 0;
   int cyc = 0;
   logic [DW-1:0] m_byte = '0;
   logic [DW-1:0] exp_q[$];
   logic full_prev = 1'b0;

   always #2 clk = ~clk;

   assign sd_i = cfg_master ? m_sd : s_sd;

   ssrx_ctrl #(.DATA_W(DW), .CLK_DIV(DIV), .SYNC_STAGES(2)) dut_i (
      .clk(clk), .rst_n(rst_n), .cfg_master(cfg_master),
      .ctl_we(ctl_we), .ctl_wdata(ctl_wdata), .sts_we(sts_we),
      .sts_wdata(sts_wdata), .rd_strobe(rd_strobe), .rd_data(rd_data),
      .ctl_rdata(ctl_rdata), .rx_full(rx_full), .overrun(overrun),
      .irq_rx(irq_rx), .irq_err(irq_err), .sck_o(sck_o),
      .sck_i(s_sck), .sd_i(sd_i)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // Master data model: put next bit out on each falling serial clock edge
   always @(negedge sck_o) begin
      sck_falls++;
      if (m_idx < DW) m_sd = m_byte[DW-1-m_idx];
      m_idx++;
   end

   // Scoreboard monitor: compare each new byte against the queue
   always @(negedge clk) begin
      if (rst_n && rx_full && !full_prev) begin
         checks++;
         if (exp_q.size() == 0) begin
            errors++;
            $display("FAIL R3 unexpected byte actual=%0h expected=none", rd_data);
         end else begin
            logic [DW-1:0] e;
            e = exp_q.pop_front();
            if (rd_data !== e) begin
               errors++;
               $display("FAIL R3 byte actual=%0h expected=%0h", rd_data, e);
            end
         end
      end
      full_prev = rx_full;
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > 100000) begin
         errors++;
         $display("FAIL watchdog actual=%0d expected=<100000", cyc);
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   task automatic ctl_write(input logic [3:0] v);
      @(negedge clk); ctl_we = 1'b1; ctl_wdata = v;
      @(negedge clk); ctl_we = 1'b0;
   endtask

   task automatic sts_clear();
      @(negedge clk); sts_we = 1'b1; sts_wdata = 1'b0;
      @(negedge clk); sts_we = 1'b0;
   endtask

   task automatic do_read();
      @(negedge clk); rd_strobe = 1'b1;
      @(negedge clk); rd_strobe = 1'b0;
   endtask

   // Master frame started by a read; checks the exact arrival cycle (R3)
   task automatic master_frame(input logic [DW-1:0] b);
      int n;
      int f0;
      exp_q.push_back(b);
      m_byte = b;
      m_idx = 0;
      f0 = sck_falls;
      do_read();
      n = 0;
      while (!rx_full && n < 200) begin
         @(negedge clk); n++;
      end
      check("R3 latency", n, LAT);
      check("R1 edges per frame", sck_falls - f0, DW);
      check("R1 idle high", sck_o, 1'b1);
   endtask

   task automatic slave_frame(input logic [DW-1:0] b);
      for (int i = DW - 1; i >= 0; i--) begin
         @(negedge clk); s_sck = 1'b0; s_sd = b[i];
         repeat (4) @(negedge clk);
         s_sck = 1'b1;
         repeat (4) @(negedge clk);
      end
      repeat (8) @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R3 reset rx_full", rx_full, 1'b0);
      check("R8 reset overrun", overrun, 1'b0);
      check("R1 reset sck", sck_o, 1'b1);
      check("R4 reset irqs", {irq_rx, irq_err}, 2'b00);
      check("R7 reset ctl", ctl_rdata, 4'h0);

      // R2: read while disabled gives no clocks
      do_read();
      repeat (40) @(negedge clk);
      check("R2 no clock when disabled", sck_falls, 0);

      // R2: enabled, no read, no clocks
      ctl_write(4'b0001);
      repeat (40) @(negedge clk);
      check("R2 no clock without read", sck_falls, 0);

      // Master frames: first read is the dummy read
      master_frame(8'hA5);
      check("R4 irq_rx masked", irq_rx, 1'b0);
      ctl_write(4'b0101);
      check("R4 irq_rx set", irq_rx, 1'b1);
      master_frame(8'h3C);
      check("R5 full cleared by read", rx_full, 1'b1);
      master_frame(8'h01);
      master_frame(8'hFE);

      // R7: stop request, one last frame
      ctl_write(4'b0011);
      master_frame(8'h96);
      check("R7 enable and stop cleared", ctl_rdata[1:0], 2'b00);
      begin
         int f1;
         f1 = sck_falls;
         do_read();
         check("R5 read clears full", rx_full, 1'b0);
         repeat (40) @(negedge clk);
         check("R7 no clocks after stop", sck_falls - f1, 0);
         check("R7 byte kept", rd_data, 8'h96);
      end

      // R6: slave mode
      cfg_master = 1'b0;
      ctl_write(4'b1001);
      exp_q.push_back(8'h5A);
      slave_frame(8'h5A);
      check("R6 slave full", rx_full, 1'b1);
      do_read();
      exp_q.push_back(8'hC3);
      slave_frame(8'hC3);

      // R8: overrun (no read of C3)
      slave_frame(8'h77);
      check("R8 overrun set", overrun, 1'b1);
      check("R8 old byte kept", rd_data, 8'hC3);
      check("R4 irq_err", irq_err, 1'b1);

      // R9: ignored while overrun
      do_read();
      slave_frame(8'h11);
      check("R9 frame ignored full", rx_full, 1'b0);
      check("R9 frame ignored data", rd_data, 8'hC3);
      sts_clear();
      check("R9 overrun cleared", overrun, 1'b0);
      exp_q.push_back(8'h42);
      slave_frame(8'h42);
      check("R9 resumes", rd_data, 8'h42);
      check("R3 queue drained", exp_q.size(), 0);

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule